// File: doc/BRIEF.md
# SPI Bit-Rate Code Calculator

This unit turns a main clock frequency and a requested serial bit rate into the two codes of a two-stage clock divider. The serial clock that results is `main / (2 << div) / (2 * (brg + 1))`. The prescale code `div` is 2 bits wide and runs from 0 to 3. The baud code `brg` is 6 bits wide and is legal from 4 to 63. The chosen pair gives the requested rate, or the nearest slower rate that the divider can make. When the request lies beyond what the divider can reach, the codes are clamped to the limit on that side and a flag reports it.

The unit works in steps and holds a single restoring shift-and-subtract divider. After a start pulse it takes three quotients in turn on that divider:

- the raw ratio `main / rate`;
- the fastest legal rate, `main / 20`;
- the slowest legal rate, `main / 2049 + 1`.

It then scans the four prescale settings in a single cycle and raises `done` for one cycle. The codes, the flags and both rate limits stay on the outputs until the next accepted start.

Top module: `spi_baud_calc`

## Requirements
- R1: With Q = floor(main/rate), the unit tries div = 0, 1, 2, 3 in that order. For each it forms q = Q >> (div+2) and takes the first div where 5 <= q <= 64. It reports that div, brg = q-1 and clamped = 0.
- R2: If q < 5 at the first setting tried (the request is too fast), the result is div = 0, brg = 4, clamped = 1.
- R3: If no setting gives q <= 64 (the request is too slow), the result is div = 3, brg = 63, clamped = 1.
- R4: `max_rate` equals floor(main/20).
- R5: `min_rate` equals floor(main/2049) + 1.
- R6: `range_err` is 1 exactly when rate > `max_rate` or rate < `min_rate`. A request equal to either limit is not an error. A request one below `min_rate` may still give unclamped codes while it raises `range_err`.
- R7: A rate of zero gives div = 3, brg = 63, clamped = 1 and range_err = 1, and no rate quotient is taken. Both limits are still reported.
- R8: Inputs are sampled only on a start pulse while `busy` is low. `busy` stays high until the result is ready. A start that arrives while busy is ignored.
- R9: `done` is a pulse one cycle long, and it never coincides with `busy`.
- R10: While idle, all result outputs hold their values until the next accepted start, whatever the inputs do.
- R11: Every reported `brg` lies in 4..63, and any clamped result also raises `range_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation (ignored while busy) |
| main_hz | input | W | Main clock frequency |
| rate_hz | input | W | Requested serial bit rate |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle result strobe |
| div_code | output | 2 | Prescale code |
| brg_code | output | 6 | Baud code |
| clamped | output | 1 | Codes saturated at a limit |
| range_err | output | 1 | Request outside the legal rate range |
| min_rate | output | W | Slowest legal rate for this main clock |
| max_rate | output | W | Fastest legal rate for this main clock |

## Verification
Four things are checked on every cycle:

- the handshake: `done` is a single-cycle pulse apart from `busy`, and `busy` only rises after a start;
- that outputs hold steady while idle;
- the legal `brg` range on each strobe;
- that any clamped result carries `range_err`.

The arithmetic itself can only be shown by scenarios with known answers. These cover the prescale search landing on each setting, both clamps, requests exactly at and one past each limit, the zero-rate rejection, and a start issued mid-calculation with other inputs.

// File: rtl/spi_baud_calc.sv
module spi_baud_calc #(
  parameter int W      = 32,
  parameter int BRG_LO = 4,
  parameter int BRG_HI = 63
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] main_hz,
  input  logic [W-1:0] rate_hz,
  output logic         busy,
  output logic         done,
  output logic [1:0]   div_code,
  output logic [5:0]   brg_code,
  output logic         clamped,
  output logic         range_err,
  output logic [W-1:0] min_rate,
  output logic [W-1:0] max_rate
);
  localparam int CW = $clog2(W + 1);
  localparam logic [W-1:0] FAST_DIV = W'(4 * (BRG_LO + 1));
  localparam logic [W-1:0] SLOW_DIV = W'(32 * (BRG_HI + 1) + 1);
  localparam logic [CW-1:0] STEPS = CW'(W);

  typedef enum logic [2:0] {S_IDLE, S_QRATE, S_QMAX, S_QMIN, S_FIN} st_t;
  st_t st;

  logic [W-1:0] main_q, rate_q, dvs, rem, quo, q_rate;
  logic [CW-1:0] cnt;

  logic [W:0] shifted, diff;
  logic ge;
  assign shifted = {rem, quo[W-1]};
  assign ge      = shifted >= {1'b0, dvs};
  assign diff    = shifted - {1'b0, dvs};
  assign busy    = (st != S_IDLE);

  logic [1:0] pick_div;
  logic [5:0] pick_brg;
  logic pick_clamp, hit;
  always_comb begin
    logic [W-1:0] qk;
    pick_div = 2'd3;
    pick_brg = 6'(BRG_HI);
    pick_clamp = 1'b1;
    hit = 1'b0;
    for (int k = 0; k < 4; k++) begin
      qk = q_rate >> (k + 2);
      if (!hit) begin
        if (qk < W'(BRG_LO + 1)) begin
          pick_div = 2'(k); pick_brg = 6'(BRG_LO); pick_clamp = 1'b1; hit = 1'b1;
        end else if (qk <= W'(BRG_HI + 1)) begin
          pick_div = 2'(k); pick_brg = 6'(qk - 1'b1); pick_clamp = 1'b0; hit = 1'b1;
        end
      end
    end
  end

  wire zero_req = (rate_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      main_q <= '0; rate_q <= '0; dvs <= '0; rem <= '0; quo <= '0; q_rate <= '0;
      cnt <= '0; done <= 1'b0;
      div_code <= '0; brg_code <= '0; clamped <= 1'b0; range_err <= 1'b0;
      min_rate <= '0; max_rate <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          main_q <= main_hz;
          rate_q <= rate_hz;
          quo <= main_hz;
          rem <= '0;
          cnt <= STEPS;
          if (rate_hz == '0) begin
            q_rate <= '0;
            dvs <= FAST_DIV;
            st <= S_QMAX;
          end else begin
            dvs <= rate_hz;
            st <= S_QRATE;
          end
        end
        S_QRATE, S_QMAX, S_QMIN: begin
          if (cnt != '0) begin
            rem <= ge ? diff[W-1:0] : shifted[W-1:0];
            quo <= {quo[W-2:0], ge};
            cnt <= cnt - 1'b1;
          end else begin
            rem <= '0;
            quo <= main_q;
            cnt <= STEPS;
            case (st)
              S_QRATE: begin q_rate <= quo; dvs <= FAST_DIV; st <= S_QMAX; end
              S_QMAX:  begin max_rate <= quo; dvs <= SLOW_DIV; st <= S_QMIN; end
              default: begin min_rate <= quo + 1'b1; st <= S_FIN; end
            endcase
          end
        end
        S_FIN: begin
          div_code  <= zero_req ? 2'd3 : pick_div;
          brg_code  <= zero_req ? 6'(BRG_HI) : pick_brg;
          clamped   <= zero_req | pick_clamp;
          range_err <= zero_req | (rate_q > max_rate) | (rate_q < min_rate);
          done <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module spi_baud_calc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic [1:0] div_code,
  input logic [5:0] brg_code,
  input logic       clamped,
  input logic       range_err
);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));
  assert_busy_from_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(div_code) && $stable(brg_code) && $stable(clamped) && $stable(range_err)));
  assert_brg_legal_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (brg_code >= 6'd4));
  assert_clamp_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && clamped) |-> range_err);
endmodule

bind spi_baud_calc spi_baud_calc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .div_code(div_code), .brg_code(brg_code), .clamped(clamped), .range_err(range_err)
);

// File: tb/tb_spi_baud_calc.sv
module tb_spi_baud_calc;
  localparam int W = 32;
  localparam int N = 12;

  logic clk = 0, rst_n = 0, start = 0;
  logic [W-1:0] main_hz = '0, rate_hz = '0;
  logic busy, done, clamped, range_err;
  logic [1:0] div_code;
  logic [5:0] brg_code;
  logic [W-1:0] min_rate, max_rate;

  spi_baud_calc #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .main_hz(main_hz), .rate_hz(rate_hz),
    .busy(busy), .done(done), .div_code(div_code), .brg_code(brg_code),
    .clamped(clamped), .range_err(range_err), .min_rate(min_rate), .max_rate(max_rate)
  );

  always #5 clk = ~clk;

  localparam int unsigned V_MAIN [N] = '{100000000, 100000000, 100000000, 100000000, 100000000, 100000000,
                                         100000000, 24000000, 24000000, 24000000, 24000000, 24000000};
  localparam int unsigned V_RATE [N] = '{1000000, 100000, 5000000, 6000000, 48805, 48804,
                                         40000, 3000000, 400000, 100000, 50000, 0};
  localparam int unsigned V_DIV  [N] = '{0, 2, 0, 0, 3, 3, 3, 0, 0, 0, 1, 3};
  localparam int unsigned V_BRG  [N] = '{24, 61, 4, 4, 63, 63, 63, 4, 14, 59, 59, 63};
  localparam int unsigned V_CLMP [N] = '{0, 0, 0, 1, 0, 0, 1, 1, 0, 0, 0, 1};
  localparam int unsigned V_ERR  [N] = '{0, 0, 0, 1, 0, 1, 1, 1, 0, 0, 0, 1};
  localparam string       V_TAG  [N] = '{"R1", "R1", "R1", "R2", "R1", "R6",
                                         "R3", "R2", "R1", "R1", "R1", "R7"};

  int checks = 0, failures = 0, cycles = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    check(done, "R8_done_seen", done, 1);
  endtask

  task automatic launch(input int unsigned m, input int unsigned r);
    @(negedge clk);
    main_hz = m; rate_hz = r; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
        finish_run();
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done, "R8_reset_idle", {busy, done}, 0);
    check(div_code == 0 && brg_code == 0 && !clamped && !range_err, "R10_reset_outputs", brg_code, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < N; i++) begin
      launch(V_MAIN[i], V_RATE[i]);
      check(busy, "R8_busy", busy, 1);
      wait_done();
      check(!busy, "R9_not_busy_with_done", busy, 0);
      check(div_code == V_DIV[i][1:0], {V_TAG[i], "_div"}, div_code, V_DIV[i]);
      check(brg_code == V_BRG[i][5:0], {V_TAG[i], "_brg"}, brg_code, V_BRG[i]);
      check(clamped == V_CLMP[i][0], {V_TAG[i], "_clamped"}, clamped, V_CLMP[i]);
      check(range_err == V_ERR[i][0], "R6_range_err", range_err, V_ERR[i]);
      check(max_rate == V_MAIN[i] / 20, "R4_max_rate", max_rate, V_MAIN[i] / 20);
      check(min_rate == V_MAIN[i] / 2049 + 1, "R5_min_rate", min_rate, V_MAIN[i] / 2049 + 1);
      @(negedge clk);
      check(!done, "R9_done_one_cycle", done, 0);
    end

    // R10: inputs move and outputs hold while idle
    main_hz = 24000000; rate_hz = 3000000;
    repeat (6) @(negedge clk);
    check(div_code == 2'd3 && brg_code == 6'd63, "R10_hold_codes", brg_code, 63);
    check(max_rate == 24000000 / 20, "R10_hold_max", max_rate, 24000000 / 20);

    // R8: a start while busy is ignored
    launch(100000000, 1000000);
    repeat (10) @(negedge clk);
    main_hz = 24000000; rate_hz = 3000000; start = 1;
    @(negedge clk);
    start = 0;
    wait_done();
    check(brg_code == 6'd24 && div_code == 2'd0, "R8_start_ignored_brg", brg_code, 24);
    check(max_rate == 5000000, "R8_start_ignored_max", max_rate, 5000000);
    repeat (3) @(negedge clk);
    check(!busy, "R8_no_second_run", busy, 0);

    // R7: zero rate, R2 at main = 0
    launch(24000000, 0);
    wait_done();
    check(range_err && clamped && div_code == 2'd3 && brg_code == 6'd63, "R7_zero_rate", brg_code, 63);
    launch(0, 1);
    wait_done();
    check(div_code == 2'd0 && brg_code == 6'd4 && clamped && range_err, "R2_zero_main", brg_code, 4);
    check(min_rate == 1 && max_rate == 0, "R5_zero_main_limits", min_rate, 1);

    finish_run();
  end
endmodule